// File: doc/BRIEF.md
# Nonvolatile Shadow Writeback Engine

This block runs beside an 8-bit user latch or register and keeps a slow nonvolatile copy of the held value up to date. It keeps a mirror of what the storage cells hold. While supply is good, it compares every captured bit with its mirror bit. When they differ, it issues a single-bit write to the storage through a request/done handshake. Bits that already match are never written, which limits wear on the cells. While a transparent user latch is open, nothing is written, because only the value held after the latch closes counts.

Writes are much slower than user captures. The engine therefore works in the background and may fall behind during a burst. Each write is chosen by a fresh scan against the live captured value. Because of this, only the newest value of a bit is ever written, and the copy reaches the final value once captures stop. While supply is out of tolerance, the mirror follows the read-back of the cells. This gives the correct starting point when power returns. The engine has no output back to the user datapath, so it cannot stall it.

Top module: `nv_shadow_sync`

## Requirements
- R1: Out of reset, `wr_req` is low. Within two cycles of reset release, with `pwr_good` low, `idle` is high when `nv_rd` equals `cap_val`.
- R2: A write is started only for a bit whose captured value differs from the mirror. The `wr_bit` issued equals the captured value of bit `wr_idx` in the cycle before `wr_req` rises.
- R3: When several bits differ, the lowest-numbered differing bit is written first.
- R4: No write starts while `cap_open` is high. Values seen while the latch is open are never written unless they are still held after it closes.
- R5: No write starts while `pwr_good` is low. A write already in flight keeps its request until `wr_done`.
- R6: At most one write is outstanding. `wr_req`, `wr_idx` and `wr_bit` stay unchanged until `wr_done` is seen.
- R7: In the cycle after `wr_req` and `wr_done` are both high, `wr_req` is low. The written bit then counts as stored.
- R8: A bit that changes and changes back before its write is issued is not written. After a burst of captures, the cells reach the final captured value.
- R9: `idle` is high only when no write is in progress and every mirror bit equals `cap_val`.
- R10: While `pwr_good` is low and no write is in flight, the mirror follows `nv_rd`. When power returns, bits that already agree cause no writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply in tolerance; writes may start only while high |
| cap_open | input | 1 | User latch is transparent; the held value is not final |
| cap_val | input | WIDTH | Value currently held by the user latch or register |
| nv_rd | input | WIDTH | Read-back of the nonvolatile cells |
| wr_req | output | 1 | Single-bit write request, held until done |
| wr_idx | output | IDXW | Index of the bit being written |
| wr_bit | output | 1 | Value being written |
| wr_done | input | 1 | Storage reports completion of the current write |
| idle | output | 1 | Mirror matches captured value and no write in progress |

## Verification
A wrong mirror bit shows up in one of two ways. Either `idle` stays low with a stray write to a bit that already matched, or `idle` rises while the cells disagree with `cap_val`. Either appears within one scan cycle after the last outstanding write completes. A faulty scan order or a stale issue value shows up on `wr_idx` and `wr_bit` in the first cycle `wr_req` is high. A broken gate on `pwr_good` or `cap_open` produces a request within one cycle of a changed captured value.

// File: rtl/nv_shadow_sync.sv
module nv_shadow_sync #(
  parameter int WIDTH = 8,
  localparam int IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_good,
  input  logic             cap_open,
  input  logic [WIDTH-1:0] cap_val,
  input  logic [WIDTH-1:0] nv_rd,
  output logic             wr_req,
  output logic [IDXW-1:0]  wr_idx,
  output logic             wr_bit,
  input  logic             wr_done,
  output logic             idle
);

  logic [WIDTH-1:0] mirror;
  logic [WIDTH-1:0] diff;
  logic [IDXW-1:0]  pick;
  logic             start;

  assign diff  = mirror ^ cap_val;
  assign start = pwr_good && !cap_open && !wr_req && (|diff);
  assign idle  = !wr_req && (diff == '0);

  always_comb begin
    pick = '0;
    for (int i = WIDTH - 1; i >= 0; i--)
      if (diff[i]) pick = IDXW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_req <= 1'b0;
      wr_idx <= '0;
      wr_bit <= 1'b0;
    end else if (wr_req) begin
      if (wr_done) wr_req <= 1'b0;
    end else if (start) begin
      wr_req <= 1'b1;
      wr_idx <= pick;
      wr_bit <= cap_val[pick];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mirror <= '0;
    else if (wr_req && wr_done)
      mirror[wr_idx] <= wr_bit;
    else if (!pwr_good && !wr_req)
      mirror <= nv_rd;
  end

endmodule

// File: rtl/nv_shadow_sync_chk.sv
module nv_shadow_sync_chk #(
  parameter int WIDTH = 8,
  parameter int IDXW = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_good,
  input logic             cap_open,
  input logic [WIDTH-1:0] cap_val,
  input logic [WIDTH-1:0] mirror,
  input logic             wr_req,
  input logic [IDXW-1:0]  wr_idx,
  input logic             wr_bit,
  input logic             wr_done,
  input logic             idle
);

  logic [WIDTH-1:0] cap_q, mir_q;
  logic             pg_q, open_q, req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0; mir_q <= '0; pg_q <= 1'b0; open_q <= 1'b1; req_q <= 1'b0;
    end else begin
      cap_q <= cap_val; mir_q <= mirror; pg_q <= pwr_good;
      open_q <= cap_open; req_q <= wr_req;
    end
  end

  // R2
  mismatch_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !req_q) |-> (wr_bit == cap_q[wr_idx]) && (wr_bit != mir_q[wr_idx]));

  // R3
  lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !req_q) |-> (((cap_q ^ mir_q) & ((WIDTH'(1) << wr_idx) - WIDTH'(1))) == '0));

  // R4
  closed_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !req_q) |-> !open_q);

  // R5
  power_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !req_q) |-> pg_q);

  // R6
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_done) |=> wr_req && $stable(wr_idx) && $stable(wr_bit));

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_done) |=> !wr_req);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !wr_req && (mirror == cap_val));

endmodule

bind nv_shadow_sync nv_shadow_sync_chk #(.WIDTH(WIDTH), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .cap_open(cap_open),
  .cap_val(cap_val), .mirror(mirror), .wr_req(wr_req), .wr_idx(wr_idx),
  .wr_bit(wr_bit), .wr_done(wr_done), .idle(idle)
);

// File: tb/test_nv_shadow_sync.sv
module test_nv_shadow_sync;
  localparam int W = 8;
  localparam int LAT = 6;

  logic clk = 0, rst_n = 0, pwr_good = 0, cap_open = 0;
  logic [W-1:0] cap_val = '0;
  logic [W-1:0] cells = '0;
  logic wr_req, wr_bit, wr_done = 0, idle;
  logic [2:0] wr_idx;
  logic preset_en = 0;
  logic [W-1:0] preset_val = '0;

  int wcnt[W];
  int total = 0, cnt = 0;
  int order[64];
  int nchk = 0, nfail = 0, cyc = 0;

  always #5 clk = ~clk;

  nv_shadow_sync #(.WIDTH(W)) i_nv_shadow_sync (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .cap_open(cap_open),
    .cap_val(cap_val), .nv_rd(cells), .wr_req(wr_req), .wr_idx(wr_idx),
    .wr_bit(wr_bit), .wr_done(wr_done), .idle(idle));

  initial for (int i = 0; i < W; i++) wcnt[i] = 0;

  always @(posedge clk) begin
    if (preset_en) cells <= preset_val;
    if (wr_done) begin
      wr_done <= 0; cnt <= 0;
    end else if (wr_req) begin
      if (cnt == LAT - 1) begin
        wr_done <= 1;
        cells[wr_idx] <= wr_bit;
        wcnt[wr_idx] <= wcnt[wr_idx] + 1;
        order[total % 64] <= int'(wr_idx);
        total <= total + 1;
      end else cnt <= cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle(input string tag);
    int t = 0;
    @(negedge clk);
    while (!idle && t < 500) begin @(negedge clk); t++; end
    chk(idle, tag, int'(idle), 1);
  endtask

  task automatic t_reset;
    cycles(2);
    chk(wr_req == 0, "R1 req after reset", int'(wr_req), 0);
    chk(idle == 1, "R1 idle after reset", int'(idle), 1);
  endtask

  task automatic t_restore;
    int t0;
    preset_val = 8'hA0; preset_en = 1; cap_val = 8'hA0;
    cycles(1); preset_en = 0; cycles(2);
    chk(idle == 1, "R10 mirror follows cells", int'(idle), 1);
    t0 = total; pwr_good = 1; cycles(20);
    chk(total == t0, "R10 no writes for matching bits", total - t0, 0);
    chk(cells == 8'hA0, "R10 cells kept", int'(cells), 'hA0);
  endtask

  task automatic t_order;
    int t0 = total;
    cap_val = 8'hA5;
    wait_idle("R8 converge single");
    chk(cells == 8'hA5, "R2 cells value", int'(cells), 'hA5);
    chk(total - t0 == 2, "R2 only changed bits", total - t0, 2);
    chk(order[t0 % 64] == 0, "R3 first bit", order[t0 % 64], 0);
    chk(order[(t0 + 1) % 64] == 2, "R3 second bit", order[(t0 + 1) % 64], 2);
  endtask

  task automatic t_same;
    int t0 = total;
    cap_val = 8'hA5; cycles(20);
    chk(total == t0, "R2 rewrite of equal value", total - t0, 0);
  endtask

  task automatic t_open;
    int t0 = total;
    cap_open = 1;
    for (int k = 0; k < 30; k++) begin cap_val = 8'(k * 37); @(negedge clk); end
    chk(wr_req == 0, "R4 no req while open", int'(wr_req), 0);
    chk(total == t0, "R4 no writes while open", total - t0, 0);
    cap_val = 8'hA4; cycles(2); cap_open = 0;
    wait_idle("R4 converge after close");
    chk(total - t0 == 1, "R4 only held value written", total - t0, 1);
    chk(cells == 8'hA4, "R4 cells value", int'(cells), 'hA4);
  endtask

  task automatic t_newest;
    int b5 = wcnt[5];
    cap_val = 8'hA5;
    @(negedge clk);
    chk(wr_req == 1, "R6 req issued", int'(wr_req), 1);
    chk(wr_idx == 0 && wr_bit == 1, "R2 issued bit", {wr_idx, wr_bit}, 1);
    cap_val = 8'h85; @(negedge clk); cap_val = 8'hA5;
    chk(idle == 0, "R9 not idle while writing", int'(idle), 0);
    wait_idle("R8 converge newest");
    chk(wcnt[5] == b5, "R8 bit5 toggle not written", wcnt[5] - b5, 0);
  endtask

  task automatic t_burst;
    for (int k = 0; k < 40; k++) begin cap_val = 8'(k * 91 + 3); @(negedge clk); end
    cap_val = 8'h3C;
    chk(idle == 0, "R9 not idle after burst", int'(idle), 0);
    wait_idle("R8 burst catch up");
    chk(cells == 8'h3C, "R8 burst final value", int'(cells), 'h3C);
  endtask

  task automatic t_power;
    int t0;
    pwr_good = 0; cap_val = 8'hC3; cycles(20);
    chk(wr_req == 0, "R5 no start without power", int'(wr_req), 0);
    chk(cells == 8'h3C, "R5 cells kept", int'(cells), 'h3C);
    chk(idle == 0, "R9 idle low on mismatch", int'(idle), 0);
    pwr_good = 1;
    @(negedge clk);
    chk(wr_req == 1, "R5 start after power back", int'(wr_req), 1);
    pwr_good = 0; t0 = total;
    cycles(LAT + 1);
    chk(wr_req == 1 || total == t0 + 1, "R5 in-flight completes", total - t0, 1);
    cycles(20);
    chk(total == t0 + 1, "R5 only in-flight write", total - t0, 1);
    chk(wr_req == 0, "R7 req released", int'(wr_req), 0);
    pwr_good = 1;
    wait_idle("R5 resume");
    chk(cells == 8'hC3, "R5 final cells", int'(cells), 'hC3);
  endtask

  initial begin
    cycles(5); rst_n = 1;
    t_reset(); t_restore(); t_order(); t_same(); t_open();
    t_newest(); t_burst(); t_power();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule